// File: doc/BRIEF.md
# Issue Queue Resize Controller

This block decides, once per fixed time quantum, whether an out-of-order issue queue should shrink or grow by one portion. The queue is a circular buffer split into equal portions, and only the enabled portions take part in wakeup. The controller's estimate of the worth of the youngest enabled portion comes from commits alone. At dispatch it tags each instruction whose physical queue slot falls in the youngest enabled portion. The tag travels with the instruction in the reorder buffer and comes back on one of the commit lanes. The controller counts tagged commits over each quantum.

At a quantum boundary the queue loses one portion if the tagged commits stayed below the throughput threshold (25 commits in 1000 cycles by default). Growth is blind: every fifth quantum the queue gains one portion whatever the statistics show. A growth that was not useful is undone by a later shrink decision. The queue logic receives one-cycle grow and shrink pulses and the current portion count.

Top module: `iq_resize_ctrl`

## Requirements
- R1: `disp_young_o` is high exactly when `disp_valid_i` is high and `disp_slot_i / PORTION_DEPTH` equals `(head_portion_i + portions_o - 1) mod NUM_PORTIONS`. This is the same cycle, with no register on the path.
- R2: A quantum is `QUANTUM_CYCLES` clock edges long, and the first quantum starts at the first edge after reset release. `grow_o` and `shrink_o` are high only in the cycle right after the last edge of a quantum. `portions_o` changes only in a cycle where one of them is high.
- R3: A commit lane counts only when both its valid bit and its tag bit are high. A lane with only one of the two bits high has no effect on any output.
- R4: At the end of a quantum that is not a grow quantum, if fewer than `SHRINK_THRESH` lanes counted over the quantum and `portions_o` is above 1, then `shrink_o` pulses and `portions_o` drops by one in that same cycle.
- R5: Every `GROW_QUANTA`-th quantum ends in a grow decision whatever the commit count. If `portions_o` is below `NUM_PORTIONS`, `grow_o` pulses and `portions_o` rises by one in that same cycle.
- R6: In a grow quantum `shrink_o` stays low, even if the commit count is below the threshold.
- R7: `portions_o` never drops below 1. A shrink decision taken at 1 portion gives no pulse.
- R8: `portions_o` never exceeds `NUM_PORTIONS`. A grow quantum taken at the full size gives no pulse.
- R9: After reset `portions_o` equals `INIT_PORTIONS` (16 by default), and `grow_o`, `shrink_o` are low.
- R10: The tagged-commit count saturates at the threshold and clears at every quantum boundary. A quantum with a very high count does not stop a shrink in the next quantum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid_i | input | 1 | An instruction is being dispatched into the queue |
| disp_slot_i | input | 7 | Physical queue slot of the dispatched instruction |
| head_portion_i | input | 4 | Portion that holds the queue head (oldest enabled portion) |
| disp_young_o | output | 1 | Tag to store with the instruction: slot lies in the youngest enabled portion |
| cmt_valid_i | input | 4 | Per-lane commit valid |
| cmt_young_i | input | 4 | Per-lane tag bit returned at commit |
| portions_o | output | 5 | Number of enabled portions (1 to 16) |
| grow_o | output | 1 | One-cycle pulse: enable one more portion |
| shrink_o | output | 1 | One-cycle pulse: disable the youngest portion |

## Verification
The dispatch tag is combinational, so the bench checks it one time unit after it drives slot, head and valid, using the portion count seen at that moment. The commit count, the quantum position and the size all change at a clock edge. The bench keeps its own quantum position, count and size, and updates them right after each rising edge. It then compares `grow_o`, `shrink_o` and `portions_o` at the next falling edge, so a decision at the last edge of a quantum is checked in the following cycle as a pulse, together with the new count. Directed quanta place exactly 24 and 25 tagged commits, a saturating burst, and long idle stretches that reach both size limits. Random quanta and idle-lane noise on the commit ports fill in the rest.

// File: rtl/iqr_pkg.sv
package iqr_pkg;

   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_GROW   = 2'd1,
      OP_SHRINK = 2'd2
   } resize_op_e;

   function automatic int unsigned width_of(int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/iqr_quantum_timer.sv
module iqr_quantum_timer
   import iqr_pkg::*;
#(
   parameter int unsigned QUANTUM_CYCLES = 1000,
   parameter int unsigned GROW_QUANTA    = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic boundary_o,
   output logic grow_due_o
);

   localparam int unsigned TW = width_of(QUANTUM_CYCLES);
   localparam int unsigned QW = width_of(GROW_QUANTA);

   logic [TW-1:0] tick;

   assign boundary_o = (tick == TW'(QUANTUM_CYCLES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)          tick <= '0;
      else if (boundary_o) tick <= '0;
      else                 tick <= tick + TW'(1);
   end

   generate
      if (GROW_QUANTA == 1) begin : g_every
         assign grow_due_o = boundary_o;
      end else begin : g_periodic
         logic [QW-1:0] qidx;
         always_ff @(posedge clk) begin
            if (!rst_n) qidx <= '0;
            else if (boundary_o)
               qidx <= (qidx == QW'(GROW_QUANTA - 1)) ? '0 : qidx + QW'(1);
         end
         assign grow_due_o = boundary_o && (qidx == QW'(GROW_QUANTA - 1));

         AST_GROW_DUE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            grow_due_o |-> boundary_o); // R5
      end
   endgenerate

endmodule

// File: rtl/iqr_flag_counter.sv
module iqr_flag_counter
   import iqr_pkg::*;
#(
   parameter int unsigned COMMIT_WIDTH  = 4,
   parameter int unsigned SHRINK_THRESH = 25
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    boundary_i,
   input  logic [COMMIT_WIDTH-1:0] cmt_valid_i,
   input  logic [COMMIT_WIDTH-1:0] cmt_young_i,
   output logic                    low_o
);

   localparam int unsigned IW = width_of(COMMIT_WIDTH + 1);
   localparam int unsigned CW = width_of(SHRINK_THRESH + COMMIT_WIDTH + 1);

   logic [IW-1:0] inc;
   logic [CW-1:0] cnt, sum, cnt_next;

   always_comb begin
      inc = '0;
      for (int i = 0; i < COMMIT_WIDTH; i++)
         inc = inc + IW'(cmt_valid_i[i] & cmt_young_i[i]);
   end

   assign sum      = cnt + CW'(inc);
   assign cnt_next = (sum >= CW'(SHRINK_THRESH)) ? CW'(SHRINK_THRESH) : sum;
   assign low_o    = (sum < CW'(SHRINK_THRESH));

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (boundary_i) cnt <= '0;
      else                 cnt <= cnt_next;
   end

   AST_CNT_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(SHRINK_THRESH)); // R10

   AST_CNT_NONDEC: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(boundary_i) |-> (cnt >= $past(cnt))); // R10

endmodule

// File: rtl/iqr_size_ctrl.sv
module iqr_size_ctrl
   import iqr_pkg::*;
#(
   parameter int unsigned NUM_PORTIONS  = 16,
   parameter int unsigned INIT_PORTIONS = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  boundary_i,
   input  logic                                  grow_due_i,
   input  logic                                  low_i,
   output logic [width_of(NUM_PORTIONS + 1)-1:0] portions_o,
   output logic                                  grow_o,
   output logic                                  shrink_o
);

   localparam int unsigned NW = width_of(NUM_PORTIONS + 1);

   resize_op_e op;

   always_comb begin
      op = OP_HOLD;
      if (boundary_i) begin
         if (grow_due_i) begin
            if (portions_o < NW'(NUM_PORTIONS)) op = OP_GROW;
         end else if (low_i && (portions_o > NW'(1))) begin
            op = OP_SHRINK;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         portions_o <= NW'(INIT_PORTIONS);
         grow_o     <= 1'b0;
         shrink_o   <= 1'b0;
      end else begin
         grow_o   <= (op == OP_GROW);
         shrink_o <= (op == OP_SHRINK);
         case (op)
            OP_GROW:   portions_o <= portions_o + NW'(1);
            OP_SHRINK: portions_o <= portions_o - NW'(1);
            default:   portions_o <= portions_o;
         endcase
      end
   end

   AST_SHRINK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      shrink_o |-> (portions_o == $past(portions_o) - NW'(1))); // R4

   AST_GROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      grow_o |-> (portions_o == $past(portions_o) + NW'(1))); // R5

   AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grow_o, shrink_o})); // R6

   AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      portions_o >= NW'(1)); // R7

   AST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      portions_o <= NW'(NUM_PORTIONS)); // R8

   AST_SIZE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(grow_o || shrink_o) |-> $stable(portions_o)); // R2

endmodule

// File: rtl/iqr_dispatch_tag.sv
module iqr_dispatch_tag
   import iqr_pkg::*;
#(
   parameter int unsigned NUM_PORTIONS  = 16,
   parameter int unsigned PORTION_DEPTH = 8
) (
   input  logic                                                 disp_valid_i,
   input  logic [width_of(NUM_PORTIONS * PORTION_DEPTH)-1:0]    disp_slot_i,
   input  logic [width_of(NUM_PORTIONS)-1:0]                    head_portion_i,
   input  logic [width_of(NUM_PORTIONS + 1)-1:0]                portions_i,
   output logic                                                 disp_young_o
);

   localparam int unsigned PB = width_of(NUM_PORTIONS);
   localparam int unsigned NW = width_of(NUM_PORTIONS + 1);
   localparam int unsigned SW = width_of(NUM_PORTIONS * PORTION_DEPTH);
   localparam int unsigned DB = SW - PB;
   localparam int unsigned AW = (PB > NW ? PB : NW) + 1;

   logic [AW-1:0] young_sum;
   logic [PB-1:0] young_idx, slot_portion;

   assign young_sum    = AW'(head_portion_i) + AW'(portions_i) - AW'(1);
   assign young_idx    = young_sum[PB-1:0];
   assign slot_portion = disp_slot_i[SW-1:DB];
   assign disp_young_o = disp_valid_i && (slot_portion == young_idx);

endmodule

// File: rtl/iq_resize_ctrl.sv
module iq_resize_ctrl
   import iqr_pkg::*;
#(
   parameter int unsigned NUM_PORTIONS   = 16,
   parameter int unsigned PORTION_DEPTH  = 8,
   parameter int unsigned INIT_PORTIONS  = 16,
   parameter int unsigned COMMIT_WIDTH   = 4,
   parameter int unsigned QUANTUM_CYCLES = 1000,
   parameter int unsigned GROW_QUANTA    = 5,
   parameter int unsigned SHRINK_THRESH  = 25,
   localparam int unsigned SW = width_of(NUM_PORTIONS * PORTION_DEPTH),
   localparam int unsigned PB = width_of(NUM_PORTIONS),
   localparam int unsigned NW = width_of(NUM_PORTIONS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    disp_valid_i,
   input  logic [SW-1:0]           disp_slot_i,
   input  logic [PB-1:0]           head_portion_i,
   output logic                    disp_young_o,
   input  logic [COMMIT_WIDTH-1:0] cmt_valid_i,
   input  logic [COMMIT_WIDTH-1:0] cmt_young_i,
   output logic [NW-1:0]           portions_o,
   output logic                    grow_o,
   output logic                    shrink_o
);

   generate
      if ((NUM_PORTIONS < 2) || ((NUM_PORTIONS & (NUM_PORTIONS - 1)) != 0))
         begin : g_bad_portions
            $error("NUM_PORTIONS must be a power of two, at least 2");
         end
      if ((PORTION_DEPTH < 2) || ((PORTION_DEPTH & (PORTION_DEPTH - 1)) != 0))
         begin : g_bad_depth
            $error("PORTION_DEPTH must be a power of two, at least 2");
         end
      if ((INIT_PORTIONS < 1) || (INIT_PORTIONS > NUM_PORTIONS))
         begin : g_bad_init
            $error("INIT_PORTIONS must lie in 1..NUM_PORTIONS");
         end
      if ((QUANTUM_CYCLES < 2) || (GROW_QUANTA < 1) || (COMMIT_WIDTH < 1) || (SHRINK_THRESH < 1))
         begin : g_bad_timing
            $error("quantum, grow period, commit width and threshold must be positive");
         end
   endgenerate

   logic boundary, grow_due, low;

   iqr_quantum_timer #(
      .QUANTUM_CYCLES(QUANTUM_CYCLES),
      .GROW_QUANTA   (GROW_QUANTA)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary_o(boundary),
      .grow_due_o(grow_due)
   );

   iqr_flag_counter #(
      .COMMIT_WIDTH (COMMIT_WIDTH),
      .SHRINK_THRESH(SHRINK_THRESH)
   ) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary_i (boundary),
      .cmt_valid_i(cmt_valid_i),
      .cmt_young_i(cmt_young_i),
      .low_o      (low)
   );

   iqr_size_ctrl #(
      .NUM_PORTIONS (NUM_PORTIONS),
      .INIT_PORTIONS(INIT_PORTIONS)
   ) u_size (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary_i(boundary),
      .grow_due_i(grow_due),
      .low_i     (low),
      .portions_o(portions_o),
      .grow_o    (grow_o),
      .shrink_o  (shrink_o)
   );

   iqr_dispatch_tag #(
      .NUM_PORTIONS (NUM_PORTIONS),
      .PORTION_DEPTH(PORTION_DEPTH)
   ) u_tag (
      .disp_valid_i  (disp_valid_i),
      .disp_slot_i   (disp_slot_i),
      .head_portion_i(head_portion_i),
      .portions_i    (portions_o),
      .disp_young_o  (disp_young_o)
   );

   AST_PULSE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (grow_o || shrink_o) |-> $past(boundary)); // R2

   AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      disp_young_o |-> disp_valid_i); // R1

endmodule

// File: tb/iq_resize_ctrl_tb.sv
module iq_resize_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NP  = 16;
   localparam int PD  = 8;
   localparam int CWD = 4;
   localparam int QC  = 1000;
   localparam int GQ  = 5;
   localparam int TH  = 25;
   localparam int NQUANTA = 45;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       disp_valid = 1'b0;
   logic [6:0] disp_slot = '0;
   logic [3:0] head_portion = '0;
   logic       disp_young;
   logic [3:0] cmt_valid = '0;
   logic [3:0] cmt_young = '0;
   logic [4:0] portions;
   logic       grow, shrink;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_tick = 0, m_cnt = 0, m_q = 0, m_size = NP, m_quantum = 0;
   bit e_grow = 0, e_shrink = 0;
   bit last_grow_q = 0;
   int remaining = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iq_resize_ctrl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .disp_valid_i  (disp_valid),
      .disp_slot_i   (disp_slot),
      .head_portion_i(head_portion),
      .disp_young_o  (disp_young),
      .cmt_valid_i   (cmt_valid),
      .cmt_young_i   (cmt_young),
      .portions_o    (portions),
      .grow_o        (grow),
      .shrink_o      (shrink)
   );

   task automatic check(string tag, int actual, int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (quantum %0d)", tag, actual, expected, m_quantum);
      end
   endtask

   function automatic int target_for(int q);
      if (q < 5)   return 100;
      if (q < 33)  return 0;
      if (q == 33) return 24;
      if (q == 34) return 25;
      if (q == 35) return 4000;
      if (q == 36) return 24;
      return int'($urandom % 50);
   endfunction

   function automatic bit exp_young(bit v, int slot, int head, int size);
      return v && ((slot / PD) == ((head + size - 1) % NP));
   endfunction

   task automatic drive_commits();
      int k, start, placed;
      k = int'($urandom % 5);
      if (remaining > 4 * (QC - m_tick - 1)) k = 4;
      if (k > remaining) k = remaining;
      start = int'($urandom % CWD);
      placed = 0;
      for (int j = 0; j < CWD; j++) begin
         int lane;
         lane = (start + j) % CWD;
         if (placed < k) begin
            cmt_valid[lane] = 1'b1;
            cmt_young[lane] = 1'b1;
            placed++;
         end else if ($urandom % 2 == 0) begin
            cmt_valid[lane] = 1'b1;          // R3: unflagged commit
            cmt_young[lane] = 1'b0;
         end else begin
            cmt_valid[lane] = 1'b0;          // R3: stray tag without valid
            cmt_young[lane] = 1'($urandom % 2);
         end
      end
      remaining -= k;
   endtask

   task automatic model_edge();
      int inc;
      inc = 0;
      for (int j = 0; j < CWD; j++) inc += int'(cmt_valid[j] & cmt_young[j]);
      e_grow = 0;
      e_shrink = 0;
      if (m_tick == QC - 1) begin
         last_grow_q = (m_q == GQ - 1);
         if (last_grow_q) begin
            if (m_size < NP) begin m_size++; e_grow = 1; end
         end else if ((m_cnt + inc) < TH && m_size > 1) begin
            m_size--; e_shrink = 1;
         end
         m_cnt = 0;
         m_q = (m_q == GQ - 1) ? 0 : m_q + 1;
         m_tick = 0;
         m_quantum++;
      end else begin
         m_cnt += inc;
         m_tick++;
      end
   endtask

   task automatic check_outputs();
      string stag, ctag;
      stag = last_grow_q ? "R6" : "R4 R3 R10";
      if (m_size == 1)       ctag = "R7";
      else if (m_size == NP) ctag = "R8";
      else                   ctag = "R2";
      check("R5 grow", int'(grow), int'(e_grow));
      check({stag, " shrink"}, int'(shrink), int'(e_shrink));
      check({ctag, " portions"}, int'(portions), m_size);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R9 reset portions", int'(portions), NP);
      check("R9 reset grow", int'(grow), 0);
      check("R9 reset shrink", int'(shrink), 0);
      rst_n = 1'b1;
      while (m_quantum < NQUANTA) begin
         if (m_tick == 0) remaining = target_for(m_quantum);
         disp_valid   = 1'($urandom % 4 != 0);
         disp_slot    = 7'($urandom);
         head_portion = 4'($urandom);
         drive_commits();
         #1;
         check("R1 tag", int'(disp_young),
               int'(exp_young(disp_valid, int'(disp_slot), int'(head_portion), m_size)));
         @(posedge clk);
         model_edge();
         @(negedge clk);
         check_outputs();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule